// File: doc/BRIEF.md
# CAN Transmit Request Arbiter

This block decides which of a bank of CAN transmit holding buffers is offered next to the frame engine. Software raises a per-buffer transmit request with a set mask. It can also raise a per-buffer remote-frame reply request. The arbiter keeps both sets of pending flags. While the frame engine is idle, it offers exactly one of them as a grant, made of a valid flag, a buffer index and a bit that tells a remote reply from a data message.

Remote-frame replies always win over data messages, and among them the lowest index wins. For data messages, a configuration input picks the policy. In fixed order the lowest pending index wins. In rotating order a search pointer walks the indices upward and wraps, so every buffer gets its turn. The frame engine ends each attempt with a single-cycle sent pulse or a lost pulse. A send clears the flag that was served and raises a sticky interrupt. A loss leaves the flag pending so the message is tried again. The arbiter picks afresh after either outcome. Message storage lives outside the block. The arbiter only gates its write strobes, so that a buffer with a pending request cannot be overwritten.

Top module: `can_tx_arbiter`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), grant_valid, tx_msg_irq and every pending flag are 0, and the rotating pointer is at index 0.
- R2: A 1 in bit i of txreq_set (or rtrreq_set) at a clock edge sets bit i of txreq_pend (or rtrreq_pend). The flag then stays set until its own message is sent.
- R3: With cfg_fixed = 1 and no remote request pending, the grant goes to the lowest-index buffer whose transmit flag is set.
- R4: With cfg_fixed = 0, the data search starts at the rotating pointer and runs upward, wrapping from NBUF-1 to 0. A send from buffer k moves the pointer to k+1 (modulo NBUF). A loss by buffer k sets the pointer to k, so that buffer is searched first again.
- R5: Whenever any remote request is pending, the grant goes to the lowest-index one, with grant_rtr = 1, in both modes. Remote grants never move the rotating pointer.
- R6: A new grant is raised at a clock edge only if no grant is outstanding and fr_ready is 1. An outstanding grant keeps its index and kind unchanged until fr_done or fr_lost.
- R7: fr_done during a grant drops grant_valid and clears the served flag. If it was a data message, it also sets tx_msg_irq. A txreq_set on the same buffer in the same cycle wins, and that flag stays set.
- R8: fr_lost (without fr_done) during a grant drops grant_valid and leaves every pending flag set. The next grant is chosen from the same rules.
- R9: tx_msg_irq stays at 1 until a cycle with irq_clr = 1. If a data send completes in that same cycle, the bit stays at 1.
- R10: buf_we is the one-hot decode of wr_idx when wr_en = 1 and txreq_pend[wr_idx] = 0. Otherwise it is all zero, so writes to a pending buffer are dropped.
- R11: fr_done and fr_lost pulses while no grant is outstanding change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fixed | input | 1 | 1 = fixed lowest-index order, 0 = rotating order |
| txreq_set | input | NBUF | Per-buffer transmit request set mask |
| rtrreq_set | input | NBUF | Per-buffer remote reply request set mask |
| irq_clr | input | 1 | Write-1 clear of tx_msg_irq |
| wr_en | input | 1 | Software write to buffer storage |
| wr_idx | input | $clog2(NBUF) | Target buffer of the write |
| buf_we | output | NBUF | Gated per-buffer storage write strobe |
| fr_ready | input | 1 | Frame engine is idle and can accept a grant |
| fr_done | input | 1 | Pulse: granted message was sent |
| fr_lost | input | 1 | Pulse: granted message lost bus arbitration |
| grant_valid | output | 1 | A grant is outstanding |
| grant_idx | output | $clog2(NBUF) | Granted buffer index |
| grant_rtr | output | 1 | Grant is a remote reply rather than data |
| txreq_pend | output | NBUF | Pending transmit flags |
| rtrreq_pend | output | NBUF | Pending remote reply flags |
| tx_msg_irq | output | 1 | Sticky data-sent interrupt status |

## Verification
The assertions hold on every cycle for the local rules: a grant stays still until its outcome, no grant rises while the engine is busy, and the granted flag stays pending while it is served. They also cover a loss dropping the grant without clearing the flag, the interrupt staying set, and write strobes never reaching a pending buffer. Which index wins is a property of the whole flag vector and of the pointer history, so only the bench scenarios can show it. That covers lowest-index order, wrap-around in rotating order, remote requests overtaking data, retry after loss, and a set racing a send.

// File: rtl/can_arb_pkg.sv
// Package: shared types for the CAN transmit arbiter.
// Assumes: nothing beyond the standard language.
package can_arb_pkg;

    // Data scheduling policy, as decoded from cfg_fixed.
    typedef enum logic {
        ARB_ROTATE = 1'b0,
        ARB_FIXED  = 1'b1
    } arb_mode_e;

    // Outcome of the outstanding attempt, as seen in one cycle.
    typedef enum logic [1:0] {
        EVT_NONE = 2'd0,
        EVT_SENT = 2'd1,
        EVT_LOST = 2'd2
    } fr_evt_e;

endpackage

// File: rtl/can_req_bank.sv
// Module: can_req_bank
// Holds one pending flag per buffer. Set-mask bits raise flags. A single
// indexed clear drops one flag; a set in the same cycle wins over that clear.
// Assumes: clr_idx < NBUF whenever clr_en is high.
module can_req_bank #(
    parameter int NBUF = 32,
    parameter int IDXW = $clog2(NBUF)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NBUF-1:0] set_mask,
    input  logic            clr_en,
    input  logic [IDXW-1:0] clr_idx,
    output logic [NBUF-1:0] pend
);

    for (genvar i = 0; i < NBUF; i++) begin : g_flag
        logic clr_hit;

        // Decode whether this flag is the one being cleared.
        always_comb clr_hit = clr_en && (clr_idx == IDXW'(i));

        // Flag register: set dominates clear, otherwise hold.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend[i] <= 1'b0;
            else if (set_mask[i])
                pend[i] <= 1'b1;
            else if (clr_hit)
                pend[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/can_first_set.sv
// Module: can_first_set
// Finds the first set bit of req, starting at index start and going upward,
// wrapping from NBUF-1 to 0. Purely combinational.
// Assumes: start < NBUF.
module can_first_set #(
    parameter int NBUF = 32,
    parameter int IDXW = $clog2(NBUF)
) (
    input  logic [NBUF-1:0] req,
    input  logic [IDXW-1:0] start,
    output logic            found,
    output logic [IDXW-1:0] idx
);

    // Circular scan from start; the first hit is kept.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int off = 0; off < NBUF; off++) begin
            int pos;
            pos = int'(start) + off;
            if (pos >= NBUF)
                pos = pos - NBUF;
            if (!found && req[pos]) begin
                found = 1'b1;
                idx   = IDXW'(pos);
            end
        end
    end

endmodule

// File: rtl/can_arb_ctrl.sv
// Module: can_arb_ctrl
// Grant sequencer. Raises one grant when the frame engine is idle, holds it
// until a sent or lost pulse, then tells the flag banks what to clear. It
// also keeps the rotating search pointer and the sticky sent interrupt.
// Assumes: the found/idx inputs come from the two finders over current flags.
module can_arb_ctrl
    import can_arb_pkg::*;
#(
    parameter int NBUF = 32,
    parameter int IDXW = $clog2(NBUF)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rtr_found,
    input  logic [IDXW-1:0] rtr_idx,
    input  logic            tx_found,
    input  logic [IDXW-1:0] tx_idx,
    input  logic            fr_ready,
    input  logic            fr_done,
    input  logic            fr_lost,
    input  logic            irq_clr,
    output logic            grant_valid,
    output logic [IDXW-1:0] grant_idx,
    output logic            grant_rtr,
    output logic [IDXW-1:0] rr_ptr,
    output logic            tx_clr_en,
    output logic            rtr_clr_en,
    output logic [IDXW-1:0] clr_idx,
    output logic            tx_msg_irq
);

    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NBUF - 1);

    fr_evt_e         evt;
    logic            issue;
    logic [IDXW-1:0] idx_next;

    // Classify the engine's pulses; pulses without a grant are dropped.
    always_comb begin
        if (grant_valid && fr_done)
            evt = EVT_SENT;
        else if (grant_valid && fr_lost)
            evt = EVT_LOST;
        else
            evt = EVT_NONE;
    end

    // A new grant may start only from idle with something pending.
    always_comb issue = !grant_valid && fr_ready && (rtr_found || tx_found);

    // Successor of the granted index with wrap-around.
    always_comb idx_next = (grant_idx == LAST_IDX) ? '0 : grant_idx + 1'b1;

    // Grant register: drop on an outcome, load on issue, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid <= 1'b0;
            grant_idx   <= '0;
            grant_rtr   <= 1'b0;
        end else if (evt != EVT_NONE) begin
            grant_valid <= 1'b0;
        end else if (issue) begin
            grant_valid <= 1'b1;
            grant_rtr   <= rtr_found;
            grant_idx   <= rtr_found ? rtr_idx : tx_idx;
        end
    end

    // Rotating pointer: moves past a sent data buffer, parks on a lost one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rr_ptr <= '0;
        else if (evt == EVT_SENT && !grant_rtr)
            rr_ptr <= idx_next;
        else if (evt == EVT_LOST && !grant_rtr)
            rr_ptr <= grant_idx;
    end

    // Sticky interrupt: a data send sets it, software clear drops it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_msg_irq <= 1'b0;
        else if (evt == EVT_SENT && !grant_rtr)
            tx_msg_irq <= 1'b1;
        else if (irq_clr)
            tx_msg_irq <= 1'b0;
    end

    // Clear commands toward the two flag banks.
    always_comb begin
        tx_clr_en  = (evt == EVT_SENT) && !grant_rtr;
        rtr_clr_en = (evt == EVT_SENT) && grant_rtr;
        clr_idx    = grant_idx;
    end

endmodule

// File: rtl/can_tx_arbiter.sv
// Module: can_tx_arbiter (top)
// Picks the next CAN transmit buffer for the frame engine. Remote replies
// come first in index order. Data requests are served in fixed or
// rotating order, as cfg_fixed selects. Storage write strobes are gated so
// that a buffer with a pending request keeps its contents.
// Assumes: the engine pulses fr_done/fr_lost for one cycle per attempt.
module can_tx_arbiter
    import can_arb_pkg::*;
#(
    parameter  int NBUF = 32,
    localparam int IDXW = $clog2(NBUF)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_fixed,
    input  logic [NBUF-1:0] txreq_set,
    input  logic [NBUF-1:0] rtrreq_set,
    input  logic            irq_clr,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    output logic [NBUF-1:0] buf_we,
    input  logic            fr_ready,
    input  logic            fr_done,
    input  logic            fr_lost,
    output logic            grant_valid,
    output logic [IDXW-1:0] grant_idx,
    output logic            grant_rtr,
    output logic [NBUF-1:0] txreq_pend,
    output logic [NBUF-1:0] rtrreq_pend,
    output logic            tx_msg_irq
);

    arb_mode_e       mode;
    logic [IDXW-1:0] rr_ptr;
    logic [IDXW-1:0] tx_start;
    logic            tx_found;
    logic [IDXW-1:0] tx_idx;
    logic            rtr_found;
    logic [IDXW-1:0] rtr_idx;
    logic            tx_clr_en;
    logic            rtr_clr_en;
    logic [IDXW-1:0] clr_idx;

    // Decode the policy bit and choose where the data search begins.
    always_comb begin
        mode     = arb_mode_e'(cfg_fixed);
        tx_start = (mode == ARB_FIXED) ? '0 : rr_ptr;
    end

    can_req_bank #(.NBUF(NBUF), .IDXW(IDXW)) u_tx_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (txreq_set),
        .clr_en   (tx_clr_en),
        .clr_idx  (clr_idx),
        .pend     (txreq_pend)
    );

    can_req_bank #(.NBUF(NBUF), .IDXW(IDXW)) u_rtr_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (rtrreq_set),
        .clr_en   (rtr_clr_en),
        .clr_idx  (clr_idx),
        .pend     (rtrreq_pend)
    );

    can_first_set #(.NBUF(NBUF), .IDXW(IDXW)) u_tx_find (
        .req   (txreq_pend),
        .start (tx_start),
        .found (tx_found),
        .idx   (tx_idx)
    );

    can_first_set #(.NBUF(NBUF), .IDXW(IDXW)) u_rtr_find (
        .req   (rtrreq_pend),
        .start ('0),
        .found (rtr_found),
        .idx   (rtr_idx)
    );

    can_arb_ctrl #(.NBUF(NBUF), .IDXW(IDXW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .rtr_found   (rtr_found),
        .rtr_idx     (rtr_idx),
        .tx_found    (tx_found),
        .tx_idx      (tx_idx),
        .fr_ready    (fr_ready),
        .fr_done     (fr_done),
        .fr_lost     (fr_lost),
        .irq_clr     (irq_clr),
        .grant_valid (grant_valid),
        .grant_idx   (grant_idx),
        .grant_rtr   (grant_rtr),
        .rr_ptr      (rr_ptr),
        .tx_clr_en   (tx_clr_en),
        .rtr_clr_en  (rtr_clr_en),
        .clr_idx     (clr_idx),
        .tx_msg_irq  (tx_msg_irq)
    );

    for (genvar i = 0; i < NBUF; i++) begin : g_we
        // Storage strobe for buffer i: only when addressed and not pending.
        always_comb buf_we[i] = wr_en && (wr_idx == IDXW'(i)) && !txreq_pend[i];
    end

endmodule

// File: rtl/can_tx_arbiter_chk.sv
// Module: can_tx_arbiter_chk
// Cycle-level checks on the arbiter's ports, bound into every instance.
// Assumes: rst_n is synchronous and active low.
module can_tx_arbiter_chk #(
    parameter  int NBUF = 32,
    localparam int IDXW = $clog2(NBUF)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            irq_clr,
    input logic [NBUF-1:0] buf_we,
    input logic            fr_ready,
    input logic            fr_done,
    input logic            fr_lost,
    input logic            grant_valid,
    input logic [IDXW-1:0] grant_idx,
    input logic            grant_rtr,
    input logic [NBUF-1:0] txreq_pend,
    input logic [NBUF-1:0] rtrreq_pend,
    input logic            tx_msg_irq
);

    // R6
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && !fr_done && !fr_lost |=>
            grant_valid && $stable(grant_idx) && $stable(grant_rtr));

    // R6
    busy_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid && !fr_ready |=> !grant_valid);

    // R7
    data_grant_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && !grant_rtr |-> txreq_pend[grant_idx]);

    // R5
    rtr_grant_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && grant_rtr |-> rtrreq_pend[grant_idx]);

    // R8
    lost_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && fr_lost && !fr_done |=> !grant_valid);

    // R8
    lost_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && !grant_rtr && fr_lost && !fr_done |=>
            txreq_pend[$past(grant_idx)]);

    // R9
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_msg_irq && !irq_clr |=> tx_msg_irq);

    // R7
    irq_on_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && !grant_rtr && fr_done |=> tx_msg_irq);

    // R10
    always_comb begin
        if (rst_n) begin
            we_onehot_chk: assert ($onehot0(buf_we));
            we_locked_chk: assert ((buf_we & txreq_pend) == '0);
        end
    end

endmodule

bind can_tx_arbiter can_tx_arbiter_chk #(.NBUF(NBUF)) u_chk (.*);

// File: tb/sim_can_tx_arbiter.sv
// Bench for can_tx_arbiter: directed corner cases followed by seeded random
// traffic, with every output compared each cycle against a bench model.
module sim_can_tx_arbiter;

    localparam int CLK_P = 10;
    localparam int NB    = 32;
    localparam int IW    = $clog2(NB);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_fixed;
    logic [NB-1:0] txreq_set;
    logic [NB-1:0] rtrreq_set;
    logic          irq_clr;
    logic          wr_en;
    logic [IW-1:0] wr_idx;
    logic [NB-1:0] buf_we;
    logic          fr_ready;
    logic          fr_done;
    logic          fr_lost;
    logic          grant_valid;
    logic [IW-1:0] grant_idx;
    logic          grant_rtr;
    logic [NB-1:0] txreq_pend;
    logic [NB-1:0] rtrreq_pend;
    logic          tx_msg_irq;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  ended   = 0;

    // Bench model state
    logic [NB-1:0] m_tx, m_rtr;
    logic          m_gv, m_grtr, m_irq;
    int            m_gidx, m_ptr;

    can_tx_arbiter #(.NBUF(NB)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_fixed(cfg_fixed),
        .txreq_set(txreq_set), .rtrreq_set(rtrreq_set), .irq_clr(irq_clr),
        .wr_en(wr_en), .wr_idx(wr_idx), .buf_we(buf_we),
        .fr_ready(fr_ready), .fr_done(fr_done), .fr_lost(fr_lost),
        .grant_valid(grant_valid), .grant_idx(grant_idx), .grant_rtr(grant_rtr),
        .txreq_pend(txreq_pend), .rtrreq_pend(rtrreq_pend), .tx_msg_irq(tx_msg_irq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic [NB-1:0] bit_of(input int i);
        logic [NB-1:0] v;
        v = '0;
        v[i] = 1'b1;
        return v;
    endfunction

    // First set bit at or above s, wrapping; -1 if none.
    function automatic int first_from(input logic [NB-1:0] v, input int s);
        for (int k = 0; k < NB; k++) begin
            int p;
            p = (s + k) % NB;
            if (v[p]) return p;
        end
        return -1;
    endfunction

    // Advance the model across one clock edge from the requirements.
    task automatic model_step();
        bit sent, lost, issue;
        logic [NB-1:0] tclr, rclr;
        sent  = m_gv && fr_done;
        lost  = m_gv && fr_lost && !fr_done;
        issue = !m_gv && fr_ready && ((m_rtr != '0) || (m_tx != '0));
        tclr  = (sent && !m_grtr) ? bit_of(m_gidx) : '0;
        rclr  = (sent && m_grtr) ? bit_of(m_gidx) : '0;
        if (sent && !m_grtr) m_ptr = (m_gidx + 1) % NB;
        else if (lost && !m_grtr) m_ptr = m_gidx;
        m_irq = (sent && !m_grtr) ? 1'b1 : (irq_clr ? 1'b0 : m_irq);
        if (sent || lost) m_gv = 1'b0;
        else if (issue) begin
            m_gv = 1'b1;
            if (m_rtr != '0) begin
                m_grtr = 1'b1;
                m_gidx = first_from(m_rtr, 0);
            end else begin
                m_grtr = 1'b0;
                m_gidx = first_from(m_tx, cfg_fixed ? 0 : m_ptr);
            end
        end
        m_tx  = (m_tx & ~tclr) | txreq_set;
        m_rtr = (m_rtr & ~rclr) | rtrreq_set;
    endtask

    task automatic compare();
        logic [NB-1:0] we_exp;
        we_exp = (wr_en && !m_tx[wr_idx]) ? bit_of(int'(wr_idx)) : '0;
        chk("R6 grant_valid", 64'(grant_valid), 64'(m_gv));
        if (m_gv) begin
            chk("R3/R4/R5 grant_idx", 64'(grant_idx), 64'(m_gidx));
            chk("R5 grant_rtr", 64'(grant_rtr), 64'(m_grtr));
        end
        chk("R2/R7/R8/R11 txreq_pend", 64'(txreq_pend), 64'(m_tx));
        chk("R2/R5 rtrreq_pend", 64'(rtrreq_pend), 64'(m_rtr));
        chk("R9 tx_msg_irq", 64'(tx_msg_irq), 64'(m_irq));
        chk("R10 buf_we", 64'(buf_we), 64'(we_exp));
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic idle_inputs();
        txreq_set = '0; rtrreq_set = '0; irq_clr = 0;
        wr_en = 0; wr_idx = '0; fr_done = 0; fr_lost = 0;
    endtask

    // Watchdog: a hang counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; cfg_fixed = 1; fr_ready = 1;
        idle_inputs();
        txreq_set = '1;                     // reset must override sets
        repeat (3) @(posedge clk);
        @(negedge clk);
        m_tx = '0; m_rtr = '0; m_gv = 0; m_grtr = 0; m_irq = 0; m_gidx = 0; m_ptr = 0;
        // R1: reset state
        chk("R1 grant_valid", 64'(grant_valid), 0);
        chk("R1 txreq_pend", 64'(txreq_pend), 0);
        chk("R1 rtrreq_pend", 64'(rtrreq_pend), 0);
        chk("R1 tx_msg_irq", 64'(tx_msg_irq), 0);
        rst_n = 1;
        idle_inputs();

        // R3: fixed order picks the lowest index
        txreq_set = bit_of(3) | bit_of(5) | bit_of(20);
        cycle(); idle_inputs();
        cycle();
        chk("R3 first grant", 64'(grant_idx), 3);
        fr_done = 1; cycle(); idle_inputs();
        chk("R7 irq after send", 64'(tx_msg_irq), 1);
        cycle();
        chk("R3 second grant", 64'(grant_idx), 5);
        // R8: loss keeps the flag and retries the same buffer
        fr_lost = 1; cycle(); idle_inputs();
        chk("R8 flag kept", 64'(txreq_pend[5]), 1);
        cycle();
        chk("R8 retry", 64'(grant_idx), 5);
        fr_done = 1; cycle(); idle_inputs();
        cycle();
        chk("R3 third grant", 64'(grant_idx), 20);

        // R4: rotating order resumes after 20 and wraps
        cfg_fixed = 0;
        txreq_set = bit_of(2) | bit_of(30);
        fr_done = 1; cycle(); idle_inputs();
        cycle();
        chk("R4 after pointer", 64'(grant_idx), 30);
        fr_done = 1; cycle(); idle_inputs();
        cycle();
        chk("R4 wrap", 64'(grant_idx), 2);

        // R5: remote request overtakes a lower data index
        rtrreq_set = bit_of(7); txreq_set = bit_of(0); irq_clr = 1;
        fr_done = 1; cycle(); idle_inputs();
        chk("R9 cleared", 64'(tx_msg_irq), 1);  // send and clear together
        irq_clr = 1; cycle(); idle_inputs();
        chk("R9 clear", 64'(tx_msg_irq), 0);
        chk("R5 remote grant", 64'({grant_rtr, 5'(grant_idx)}), 64'({1'b1, 5'd7}));
        fr_done = 1; cycle(); idle_inputs();
        chk("R5 no irq for remote", 64'(tx_msg_irq), 0);
        cycle();
        chk("R5 then data", 64'(grant_idx), 0);

        // R7: set racing a send keeps the buffer pending
        txreq_set = bit_of(0); fr_done = 1; cycle(); idle_inputs();
        chk("R7 set wins", 64'(txreq_pend[0]), 1);
        // R10: write lock, checked combinationally
        wr_en = 1; wr_idx = 5'd0; #1;
        chk("R10 locked", 64'(buf_we), 0);
        wr_idx = 5'd9; #1;
        chk("R10 open", 64'(buf_we), 64'(bit_of(9)));
        idle_inputs();
        // R6: busy engine blocks a grant
        fr_ready = 0; cycle(); cycle();
        chk("R6 no grant while busy", 64'(grant_valid), 0);
        fr_ready = 1; cycle();
        // R11: pulses without grant are handled by random phase below too

        // Random phase
        for (int n = 0; n < 6000; n++) begin
            int r;
            idle_inputs();
            if (n % 700 == 0) cfg_fixed = ~cfg_fixed;
            fr_ready = ($urandom % 4) != 0;
            r = $urandom % 8;
            if (m_gv) begin
                if (r < 2) fr_done = 1;
                else if (r == 2) fr_lost = 1;
            end else if (r == 7) begin
                fr_done = $urandom % 2;   // R11: no grant outstanding
                fr_lost = !fr_done;
            end
            if ($urandom % 4 == 0) txreq_set = $urandom & $urandom & $urandom;
            if ($urandom % 16 == 0) rtrreq_set = bit_of($urandom % NB);
            irq_clr = ($urandom % 8) == 0;
            wr_en = $urandom % 2;
            wr_idx = IW'($urandom % NB);
            cycle();
        end

        ended = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule